// File: doc/BRIEF.md
# Multi-Bit Control Field Checker

This block keeps a small control register whose three switches are each stored as a four-bit redundant code rather than as a single bit. The switches are the core enable, the software-application enable and the state-readout enable. Only the pattern 4'h6 means "on" and only 4'h9 means "off". The block turns each field into a single-bit enable. A field that holds any other pattern is treated as off, and it sets a sticky recoverable-alert bit. Two of the enables are also gated by an external eight-bit permit vector. They are on only while that vector holds its one permitting code.

Software reaches the block through a plain one-cycle write port and a combinational read port. A lock bit guards the control register. The lock starts set, software can clear it by writing 0, and once it is cleared nothing can set it again before reset. While the lock is clear, control writes are dropped.

Top module: `mbctl_guard`

## Requirements
- R1: After reset the lock reads 1, the control register reads 12'h999 (all three fields hold the off code 4'h9), the alert status reads 0, and all three enable outputs are 0.
- R2: A write to address 0 with data bit 0 equal to 0 clears the lock. A write with bit 0 equal to 1 leaves the lock unchanged, so a cleared lock stays cleared.
- R3: While the lock is 0, writes to the control register (address 1) do not change it, and the enable outputs keep their values.
- R4: The core enable (bits 3:0) drives `en_core` high only when it holds 4'h6. The values 4'h9 and every invalid pattern give 0. The enables follow the register in the cycle after the accepting write edge.
- R5: An accepted control write that carries a field other than 4'h6 or 4'h9 sets that field's status bit: bit 0 for the core field, bit 1 for the software-application field (bits 7:4), and bit 2 for the state-readout field (bits 11:8). These bits stay set after later valid writes.
- R6: A write to address 2 clears each status bit whose data bit is 0 and leaves each status bit whose data bit is 1 unchanged. It never sets a bit.
- R7: `en_swapp` and `en_stread` are 1 only when their field holds 4'h6 and `fuse_vec` equals 8'h69. Any other `fuse_vec` value forces them to 0. `en_core` ignores `fuse_vec`.
- R8: Read map: address 0 returns the lock in bit 0, address 1 returns the control fields in bits 11:0, address 2 returns the status in bits 2:0, and address 3 returns 0. All unused bits read 0, and control write data above bit 11 is discarded.
- R9: A control write that is dropped because the lock is clear sets no status bit, even if its fields are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| fuse_vec | input | 8 | External permit vector |
| en_core | output | 1 | Decoded core enable |
| en_swapp | output | 1 | Decoded, permit-gated software-application enable |
| en_stread | output | 1 | Decoded, permit-gated state-readout enable |

## Verification
Every register change lands on the clock edge that samples the write strobe. The read data and the enables are combinational from the registers, and the permit gating is combinational from `fuse_vec`. Every result is therefore due one edge after its write, and a change of `fuse_vec` shows up with no edge at all. The bench drives each write on a falling edge and releases it on the next falling edge. Between the two falling edges exactly one rising edge occurs, so when the bench samples at that second falling edge the write has fully taken effect. The bench changes `fuse_vec` and samples the enables after a short settling delay, with no clock edge in between. It sweeps all 4096 control patterns, with a permitting and a non-permitting vector for each.

// File: rtl/mbctl_pkg.sv
package mbctl_pkg;
    localparam int unsigned FIELD_W = 4;
    localparam int unsigned NFIELD  = 3;
    localparam int unsigned CTRL_W  = FIELD_W * NFIELD;
    localparam int unsigned ADDR_W  = 2;

    localparam logic [FIELD_W-1:0] MB_ON  = 4'h6;
    localparam logic [FIELD_W-1:0] MB_OFF = 4'h9;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LOCK  = 2'd0,
        ADR_CTRL  = 2'd1,
        ADR_ALERT = 2'd2,
        ADR_RSVD  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              lock;
        logic [CTRL_W-1:0] ctrl;
        logic [NFIELD-1:0] alert;
    } guard_state_t;
endpackage

// File: rtl/mbfield_decode.sv
module mbfield_decode #(
    parameter int unsigned W     = 4,
    parameter logic [W-1:0] ON_V  = 4'h6,
    parameter logic [W-1:0] OFF_V = 4'h9
) (
    input  logic [W-1:0] field,
    output logic         is_on,
    output logic         is_bad
);
    always_comb begin
        is_on  = (field == ON_V);
        is_bad = (field != ON_V) && (field != OFF_V);
    end
endmodule

// File: rtl/mbctl_permit.sv
module mbctl_permit #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] CODE = 8'h69
) (
    input  logic [W-1:0] vec,
    output logic         granted
);
    always_comb granted = (vec == CODE);
endmodule

// File: rtl/mbctl_rdmux.sv
module mbctl_rdmux
    import mbctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [NFIELD-1:0] alert,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        data = '0;
        unique case (reg_addr_e'(addr))
            ADR_LOCK:  data[0]           = lock;
            ADR_CTRL:  data[CTRL_W-1:0]  = ctrl;
            ADR_ALERT: data[NFIELD-1:0]  = alert;
            default:   data              = '0;
        endcase
    end
endmodule

// File: rtl/mbctl_guard.sv
module mbctl_guard
    import mbctl_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FUSE_W    = 8,
    parameter logic [FUSE_W-1:0] FUSE_ON = 8'h69,
    parameter logic [NFIELD-1:0] GATE_MASK = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FUSE_W-1:0] fuse_vec,
    output logic              en_core,
    output logic              en_swapp,
    output logic              en_stread
);
    guard_state_t st_d, st_q;

    logic [NFIELD-1:0] cur_on;
    logic [NFIELD-1:0] cur_bad_unused;
    logic [NFIELD-1:0] wr_on_unused;
    logic [NFIELD-1:0] wr_bad;
    logic [NFIELD-1:0] field_en;
    logic              permit_ok;

    for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
        mbfield_decode #(.W(FIELD_W), .ON_V(MB_ON), .OFF_V(MB_OFF)) u_cur (
            .field  (st_q.ctrl[gi*FIELD_W +: FIELD_W]),
            .is_on  (cur_on[gi]),
            .is_bad (cur_bad_unused[gi])
        );
        mbfield_decode #(.W(FIELD_W), .ON_V(MB_ON), .OFF_V(MB_OFF)) u_wr (
            .field  (wr_data[gi*FIELD_W +: FIELD_W]),
            .is_on  (wr_on_unused[gi]),
            .is_bad (wr_bad[gi])
        );
        if (GATE_MASK[gi]) begin : g_gated
            assign field_en[gi] = cur_on[gi] & permit_ok;
        end else begin : g_free
            assign field_en[gi] = cur_on[gi];
        end
    end

    mbctl_permit #(.W(FUSE_W), .CODE(FUSE_ON)) u_permit (
        .vec     (fuse_vec),
        .granted (permit_ok)
    );

    mbctl_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .addr  (rd_addr),
        .lock  (st_q.lock),
        .ctrl  (st_q.ctrl),
        .alert (st_q.alert),
        .data  (rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                ADR_LOCK: begin
                    if (!wr_data[0]) st_d.lock = 1'b0;
                end
                ADR_CTRL: begin
                    if (st_q.lock) begin
                        st_d.ctrl  = wr_data[CTRL_W-1:0];
                        st_d.alert = st_q.alert | wr_bad;
                    end
                end
                ADR_ALERT: begin
                    st_d.alert = st_q.alert & wr_data[NFIELD-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock  <= 1'b1;
            st_q.ctrl  <= {NFIELD{MB_OFF}};
            st_q.alert <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_core   = field_en[0];
    assign en_swapp  = field_en[1];
    assign en_stread = field_en[2];
endmodule

// File: rtl/mbctl_guard_chk.sv
module mbctl_guard_chk
    import mbctl_pkg::*;
#(
    parameter int unsigned FUSE_W = 8,
    parameter logic [FUSE_W-1:0] FUSE_ON = 8'h69
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              lock_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [NFIELD-1:0] alert_q,
    input logic [FUSE_W-1:0] fuse_vec,
    input logic              en_core,
    input logic              en_swapp,
    input logic              en_stread
);
    AST_LOCK_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !lock_q); // R2
    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> $stable(ctrl_q)); // R3
    AST_CORE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        en_core |-> ctrl_q[3:0] == MB_ON); // R4
    AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_ALERT) |=> ((alert_q & $past(alert_q)) == $past(alert_q))); // R5
    AST_CLEAR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_ALERT) |=> ((alert_q & ~$past(alert_q)) == '0)); // R6
    AST_PERMIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_vec != FUSE_ON) |-> (!en_swapp && !en_stread)); // R7
    AST_DROPPED_NO_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && wr_en && wr_addr == ADR_CTRL) |=> $stable(alert_q)); // R9
endmodule

bind mbctl_guard mbctl_guard_chk #(.FUSE_W(FUSE_W), .FUSE_ON(FUSE_ON)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .lock_q    (st_q.lock),
    .ctrl_q    (st_q.ctrl),
    .alert_q   (st_q.alert),
    .fuse_vec  (fuse_vec),
    .en_core   (en_core),
    .en_swapp  (en_swapp),
    .en_stread (en_stread)
);

// File: tb/sim_mbctl_guard.sv
module sim_mbctl_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  fuse_vec = 8'h69;
    logic        en_core, en_swapp, en_stread;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbctl_guard u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fuse_vec(fuse_vec), .en_core(en_core), .en_swapp(en_swapp),
        .en_stread(en_stread)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    function automatic logic bad(input logic [3:0] f);
        return (f != 4'h6) && (f != 4'h9);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [2:0]  exp_al;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, r); chk(r, 32'h1, "R1 lock");
        rd(2'd1, r); chk(r, 32'h999, "R1 ctrl");
        rd(2'd2, r); chk(r, 32'h0, "R1 alert");
        chk({29'd0, en_core, en_swapp, en_stread}, 32'h0, "R1 enables");
        rd(2'd3, r); chk(r, 32'h0, "R8 reserved addr");

        // R8 upper control bits discarded
        wr(2'd1, 32'hFFFF_F999);
        rd(2'd1, r); chk(r, 32'h999, "R8 upper bits");

        // Sweep every control pattern
        for (int v = 0; v < 4096; v++) begin
            logic [3:0] fa, fb, fc;
            logic [2:0] m;
            fa = v[3:0]; fb = v[7:4]; fc = v[11:8];
            wr(2'd1, 32'(v));
            rd(2'd1, r); chk(r, 32'(v), "R8 ctrl readback");
            fuse_vec = 8'h69; #0.5;
            chk({31'd0, en_core},   {31'd0, fa == 4'h6}, "R4 core");
            chk({31'd0, en_swapp},  {31'd0, fb == 4'h6}, "R7 swapp permitted");
            chk({31'd0, en_stread}, {31'd0, fc == 4'h6}, "R7 stread permitted");
            fuse_vec = (v[0]) ? 8'h68 : 8'h96; #0.5;
            chk({31'd0, en_core}, {31'd0, fa == 4'h6}, "R7 core ignores fuse");
            chk({30'd0, en_swapp, en_stread}, 32'h0, "R7 gated off");
            fuse_vec = 8'h69;
            exp_al = {bad(fc), bad(fb), bad(fa)};
            rd(2'd2, r); chk(r, {29'd0, exp_al}, "R5 alert set");
            m = 3'(v + (v >> 5));
            wr(2'd2, {29'd0, m});
            rd(2'd2, r); chk(r, {29'd0, exp_al & m}, "R6 partial clear");
            wr(2'd2, 32'h0);
            rd(2'd2, r); chk(r, 32'h0, "R6 full clear");
        end

        // R5 stickiness across a later valid write
        wr(2'd1, 32'h96A);
        wr(2'd1, 32'h666);
        rd(2'd2, r); chk(r, 32'h1, "R5 sticky");
        wr(2'd2, 32'h0);

        // R2 lock behaviour
        wr(2'd0, 32'h1);
        rd(2'd0, r); chk(r, 32'h1, "R2 write one keeps lock");
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd0, r); chk(r, 32'h0, "R2 lock cleared");
        wr(2'd0, 32'h1);
        rd(2'd0, r); chk(r, 32'h0, "R2 lock cannot be set");

        // R3 and R9 with lock clear
        wr(2'd1, 32'h123);
        rd(2'd1, r); chk(r, 32'h666, "R3 ctrl frozen");
        #0.5;
        chk({29'd0, en_core, en_swapp, en_stread}, 32'h7, "R3 enables kept");
        rd(2'd2, r); chk(r, 32'h0, "R9 no alert on dropped write");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule